// File: doc/BRIEF.md
# PLL Automatic Holdover Controller

This block decides when the charge pump of a phase-locked loop should stop driving the loop filter and float, and when it should resume. A digital lock detector watches the phase detector. Each phase-detector cycle arrives as a one-clock `pfd_tick`, and `pfd_in_win` tells whether both edges fell inside the lock window. Lock is declared after a programmable run of good cycles. A watchdog in the system clock domain notices when the selected reference has stopped producing edges. A simple counter models the lock pin charging up while lock holds.

Holdover can be entered in two ways. In external mode, a request pin drives the entry. In internal mode, entry is automatic once the loop has been locked long enough to charge the lock pin and then either the reference disappears or lock is lost. While holding, `cp_hiz` stays high. The next reference edge at the phase detector releases the charge pump. On that same edge the block issues a one-cycle synchronous reset to the feedback B counter, so the divider edges start close together. Entering holdover clears the lock detector. The loop must therefore lock again, and the pin must charge again, before another automatic entry is possible.

All interfaces are plain control and status pins. Each event is a single-cycle pulse, and nothing streams through the block, so there is no back-pressure.

Top module: `hoc_holdover_ctrl`

## Requirements
- R1: `lock_ind` rises on the clock edge that registers the N-th consecutive `pfd_tick` with `pfd_in_win`=1. N is set by `cfg_lock_len`: 00=5, 01=16, 10=64, 11=255.
- R2: While `cfg_dld_off`=1, `lock_ind` is held at 0 and internal-mode holdover is never entered.
- R3: Holdover is possible only when `cfg_hold_en`=2'b11. With any other value, neither mode engages. An active holdover ends on the next edge, with no B-counter reset.
- R4: With `cfg_ext_mode`=1 and holdover enabled, `cp_hiz` rises on the edge that samples `ext_hold_req`=1.
- R5: With `cfg_ext_mode`=0 and the controller armed, holdover starts once no `ref_tick` has been seen for `cfg_ref_timeout` clocks. `cp_hiz` then stays high for as long as no `ref_tick` arrives.
- R6: Holdover ends on the edge that samples `ref_tick`=1. In external mode this also requires `ext_hold_req`=0. On that edge `cp_hiz` falls and `b_cnt_rst` pulses high for exactly one cycle.
- R7: Entering holdover clears the lock detector. Automatic re-entry stays blocked until lock is regained and the pin counter has reached `cfg_pin_thresh` while lock held.
- R8: With `cfg_pin_cmp_en`=0, the pin is treated as always charged, so the controller arms on the cycle after lock.
- R9: In internal mode, losing lock while armed (for example, during a reference switchover) starts a holdover that ends at the next `ref_tick`.
- R10: A `pfd_tick` with `pfd_in_win`=0 clears the run count and drops `lock_ind` on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lock_len | input | 2 | Lock run-length code |
| cfg_dld_off | input | 1 | Disable digital lock detect |
| cfg_hold_en | input | 2 | Both bits must be set to allow holdover |
| cfg_ext_mode | input | 1 | 1 = external request, 0 = automatic |
| cfg_pin_cmp_en | input | 1 | Use the modelled lock-pin level |
| cfg_ref_timeout | input | TO_W | Clocks without a reference edge before it is missing |
| cfg_pin_thresh | input | PIN_W | Charge count at which the pin reads high |
| pfd_tick | input | 1 | One pulse per phase-detector cycle |
| pfd_in_win | input | 1 | Both edges of this cycle are inside the window |
| ref_tick | input | 1 | Reference-path edge at the phase detector |
| ext_hold_req | input | 1 | External holdover request |
| cp_hiz | output | 1 | Charge pump high impedance |
| b_cnt_rst | output | 1 | One-cycle synchronous reset for the B counter |
| lock_ind | output | 1 | Digital lock indication |

## Verification
The bound checker checks four rules on every cycle. Lock falls after any bad cycle, and stays down while detection is off. The charge pump is released once holdover is disabled. It is not released while the reference is silent. Every B-counter reset is a single cycle that coincides with leaving holdover on a reference edge. The bench scenarios cover the rest: exact lock run lengths for each code, the watchdog timing, the arming rules that need a relock and a charged pin, and the brief holdover after a lock loss during switchover.

// File: rtl/hoc_pkg.sv
package hoc_pkg;
  typedef enum logic {ST_TRACK = 1'b0, ST_HOLD = 1'b1} hoc_state_e;

  // run length needed for lock, per configuration code
  function automatic logic [7:0] lock_target(input logic [1:0] code);
    case (code)
      2'b00:   lock_target = 8'd5;
      2'b01:   lock_target = 8'd16;
      2'b10:   lock_target = 8'd64;
      default: lock_target = 8'd255;
    endcase
  endfunction
endpackage

// File: rtl/hoc_lock_det.sv
module hoc_lock_det #(
  parameter int RUN_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       dis,
  input  logic       pfd_tick,
  input  logic       in_win,
  input  logic [1:0] len_sel,
  output logic       locked
);
  import hoc_pkg::*;

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] target;
  logic [RUN_W-1:0] run_nx;

  assign target = RUN_W'(lock_target(len_sel));
  assign run_nx = (run_q < target) ? run_q + 1'b1 : run_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || dis) begin
      run_q  <= '0;
      locked <= 1'b0;
    end else if (pfd_tick) begin
      if (in_win) begin
        run_q  <= run_nx;
        locked <= (run_nx >= target);
      end else begin
        run_q  <= '0;
        locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hoc_ref_wdog.sv
module hoc_ref_wdog #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_tick,
  input  logic [TO_W-1:0] timeout,
  output logic            missing
);
  logic [TO_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n || ref_tick) begin
      gap_q <= '0;
    end else if (gap_q != {TO_W{1'b1}}) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assign missing = (gap_q >= timeout);
endmodule

// File: rtl/hoc_pin_model.sv
module hoc_pin_model #(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             locked,
  input  logic             cmp_en,
  input  logic [PIN_W-1:0] thresh,
  output logic             pin_high
);
  logic [PIN_W-1:0] charge_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !locked) begin
      charge_q <= '0;
    end else if (charge_q != {PIN_W{1'b1}}) begin
      charge_q <= charge_q + 1'b1;
    end
  end

  assign pin_high = !cmp_en || (charge_q >= thresh);
endmodule

// File: rtl/hoc_holdover_ctrl.sv
module hoc_holdover_ctrl #(
  parameter int RUN_W = 8,
  parameter int TO_W  = 8,
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_lock_len,
  input  logic             cfg_dld_off,
  input  logic [1:0]       cfg_hold_en,
  input  logic             cfg_ext_mode,
  input  logic             cfg_pin_cmp_en,
  input  logic [TO_W-1:0]  cfg_ref_timeout,
  input  logic [PIN_W-1:0] cfg_pin_thresh,
  input  logic             pfd_tick,
  input  logic             pfd_in_win,
  input  logic             ref_tick,
  input  logic             ext_hold_req,
  output logic             cp_hiz,
  output logic             b_cnt_rst,
  output logic             lock_ind
);
  import hoc_pkg::*;

  hoc_state_e state_q;
  logic       armed_q;
  logic       locked;
  logic       ref_missing;
  logic       pin_high;
  logic       hold_ok;
  logic       int_go;
  logic       ext_go;
  logic       enter;
  logic       ld_clr;

  assign hold_ok = &cfg_hold_en;
  assign int_go  = hold_ok && !cfg_ext_mode && !cfg_dld_off && armed_q &&
                   (ref_missing || !locked);
  assign ext_go  = hold_ok && cfg_ext_mode && ext_hold_req;
  assign enter   = (state_q == ST_TRACK) && (int_go || ext_go);
  assign ld_clr  = enter;

  hoc_lock_det #(.RUN_W(RUN_W)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ld_clr),
    .dis      (cfg_dld_off),
    .pfd_tick (pfd_tick),
    .in_win   (pfd_in_win),
    .len_sel  (cfg_lock_len),
    .locked   (locked)
  );

  hoc_ref_wdog #(.TO_W(TO_W)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .timeout  (cfg_ref_timeout),
    .missing  (ref_missing)
  );

  hoc_pin_model #(.PIN_W(PIN_W)) u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .locked   (locked),
    .cmp_en   (cfg_pin_cmp_en),
    .thresh   (cfg_pin_thresh),
    .pin_high (pin_high)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_TRACK;
      armed_q   <= 1'b0;
      b_cnt_rst <= 1'b0;
    end else begin
      b_cnt_rst <= 1'b0;
      case (state_q)
        ST_TRACK: begin
          if (enter) begin
            state_q <= ST_HOLD;
            armed_q <= 1'b0;
          end else if (!hold_ok || cfg_ext_mode || cfg_dld_off) begin
            armed_q <= 1'b0;
          end else if (locked && pin_high) begin
            armed_q <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (!hold_ok || (!cfg_ext_mode && cfg_dld_off)) begin
            state_q <= ST_TRACK;
          end else if (ref_tick && (!cfg_ext_mode || !ext_hold_req)) begin
            state_q   <= ST_TRACK;
            b_cnt_rst <= 1'b1;
          end
        end
        default: state_q <= ST_TRACK;
      endcase
    end
  end

  assign cp_hiz   = (state_q == ST_HOLD);
  assign lock_ind = locked;
endmodule

// File: rtl/hoc_holdover_chk.sv
module hoc_holdover_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_dld_off,
  input logic [1:0] cfg_hold_en,
  input logic       cfg_ext_mode,
  input logic       pfd_tick,
  input logic       pfd_in_win,
  input logic       ref_tick,
  input logic       cp_hiz,
  input logic       b_cnt_rst,
  input logic       lock_ind
);
  p_bad_cycle_drops_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pfd_tick && !pfd_in_win) |=> !lock_ind);

  p_dld_off_no_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dld_off |=> !lock_ind);

  p_disabled_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cfg_hold_en) |=> !cp_hiz);

  p_hold_without_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_hiz && !ref_tick && (&cfg_hold_en) && (cfg_ext_mode || !cfg_dld_off)) |=> cp_hiz);

  p_brst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b_cnt_rst |=> !b_cnt_rst);

  p_brst_at_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b_cnt_rst |-> (!cp_hiz && $past(cp_hiz) && $past(ref_tick)));
endmodule

bind hoc_holdover_ctrl hoc_holdover_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_dld_off  (cfg_dld_off),
  .cfg_hold_en  (cfg_hold_en),
  .cfg_ext_mode (cfg_ext_mode),
  .pfd_tick     (pfd_tick),
  .pfd_in_win   (pfd_in_win),
  .ref_tick     (ref_tick),
  .cp_hiz       (cp_hiz),
  .b_cnt_rst    (b_cnt_rst),
  .lock_ind     (lock_ind)
);

// File: tb/tb_hoc_holdover_ctrl.sv
`timescale 1ns/1ps
module tb_hoc_holdover_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_lock_len;
  logic       cfg_dld_off;
  logic [1:0] cfg_hold_en;
  logic       cfg_ext_mode;
  logic       cfg_pin_cmp_en;
  logic [7:0] cfg_ref_timeout;
  logic [7:0] cfg_pin_thresh;
  logic       pfd_tick;
  logic       pfd_in_win;
  logic       ref_tick;
  logic       ext_hold_req;
  logic       cp_hiz;
  logic       b_cnt_rst;
  logic       lock_ind;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hoc_holdover_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_lock_len(cfg_lock_len), .cfg_dld_off(cfg_dld_off),
    .cfg_hold_en(cfg_hold_en), .cfg_ext_mode(cfg_ext_mode), .cfg_pin_cmp_en(cfg_pin_cmp_en),
    .cfg_ref_timeout(cfg_ref_timeout), .cfg_pin_thresh(cfg_pin_thresh),
    .pfd_tick(pfd_tick), .pfd_in_win(pfd_in_win), .ref_tick(ref_tick),
    .ext_hold_req(ext_hold_req), .cp_hiz(cp_hiz), .b_cnt_rst(b_cnt_rst), .lock_ind(lock_ind)
  );

  // {pfd_in_win, expected lock_ind}, lock length code 00 (five cycles)
  localparam logic [1:0] VEC [12] = '{
    2'b10, 2'b10, 2'b10, 2'b10, 2'b11, 2'b11,
    2'b00, 2'b10, 2'b10, 2'b10, 2'b10, 2'b11
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pfd_pulse(input logic win);
    pfd_tick = 1'b1; ref_tick = 1'b1; pfd_in_win = win;
    step();
    pfd_tick = 1'b0; ref_tick = 1'b0; pfd_in_win = 1'b0;
    step();
  endtask

  task automatic ref_pulse();
    ref_tick = 1'b1; step(); ref_tick = 1'b0; step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pfd_tick = 1'b0; pfd_in_win = 1'b0; ref_tick = 1'b0; ext_hold_req = 1'b0;
    cfg_lock_len = 2'b00; cfg_dld_off = 1'b0; cfg_hold_en = 2'b00; cfg_ext_mode = 1'b0;
    cfg_pin_cmp_en = 1'b1; cfg_ref_timeout = 8'd20; cfg_pin_thresh = 8'd10;
    step(3);
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("reset cp_hiz", cp_hiz, 1'b0);
    chk("reset b_cnt_rst", b_cnt_rst, 1'b0);
    chk("reset lock_ind", lock_ind, 1'b0);

    // table walk: R1 run length, R10 bad cycle drops lock
    for (int v = 0; v < 12; v++) begin
      pfd_pulse(VEC[v][1]);
      chk($sformatf("R1 R10 vector %0d", v), lock_ind, VEC[v][0]);
    end

    // R1: code 01 needs sixteen cycles
    do_reset();
    cfg_lock_len = 2'b01;
    for (int i = 0; i < 15; i++) pfd_pulse(1'b1);
    chk("R1 code01 after 15", lock_ind, 1'b0);
    pfd_pulse(1'b1);
    chk("R1 code01 after 16", lock_ind, 1'b1);

    // R2: detection off, no lock, no automatic holdover
    do_reset();
    cfg_hold_en = 2'b11; cfg_dld_off = 1'b1;
    for (int i = 0; i < 6; i++) pfd_pulse(1'b1);
    chk("R2 no lock", lock_ind, 1'b0);
    step(60);
    chk("R2 no holdover", cp_hiz, 1'b0);

    // R3: one enable bit is not enough
    do_reset();
    cfg_hold_en = 2'b01; cfg_ext_mode = 1'b1; ext_hold_req = 1'b1;
    step(3);
    chk("R3 half enable", cp_hiz, 1'b0);

    // R4, R6: external holdover
    cfg_hold_en = 2'b11;
    step();
    chk("R4 external entry", cp_hiz, 1'b1);
    ext_hold_req = 1'b0;
    step(10);
    chk("R6 held until ref", cp_hiz, 1'b1);
    chk("R6 no early brst", b_cnt_rst, 1'b0);
    ref_tick = 1'b1; step(); ref_tick = 1'b0;
    chk("R6 exit cp_hiz", cp_hiz, 1'b0);
    chk("R6 exit brst", b_cnt_rst, 1'b1);
    step();
    chk("R6 brst single", b_cnt_rst, 1'b0);

    // R3: disabling during holdover releases without B reset
    ext_hold_req = 1'b1; step(); ext_hold_req = 1'b0;
    chk("R3 reenter ext", cp_hiz, 1'b1);
    cfg_hold_en = 2'b10; step();
    chk("R3 release on disable", cp_hiz, 1'b0);
    chk("R3 no brst on disable", b_cnt_rst, 1'b0);

    // R5, R6, R7: automatic holdover on missing reference
    do_reset();
    cfg_hold_en = 2'b11;
    for (int i = 0; i < 5; i++) pfd_pulse(1'b1);
    chk("R5 locked", lock_ind, 1'b1);
    for (int i = 0; i < 8; i++) ref_pulse();
    chk("R5 no entry with ref", cp_hiz, 1'b0);
    step(30);
    chk("R5 entry on missing ref", cp_hiz, 1'b1);
    step(40);
    chk("R5 stays while ref absent", cp_hiz, 1'b1);
    chk("R7 lock cleared on entry", lock_ind, 1'b0);
    ref_tick = 1'b1; step(); ref_tick = 1'b0;
    chk("R6 auto exit cp_hiz", cp_hiz, 1'b0);
    chk("R6 auto exit brst", b_cnt_rst, 1'b1);
    step(60);
    chk("R7 no reentry before relock", cp_hiz, 1'b0);
    for (int i = 0; i < 5; i++) pfd_pulse(1'b1);
    pfd_pulse(1'b0);
    step(2);
    chk("R7 no entry before pin charged", cp_hiz, 1'b0);

    // R8, R9: comparator off, lock loss gives brief holdover
    cfg_pin_cmp_en = 1'b0;
    for (int i = 0; i < 5; i++) pfd_pulse(1'b1);
    pfd_pulse(1'b0);
    chk("R8 R9 holdover on lock loss", cp_hiz, 1'b1);
    ref_tick = 1'b1; step(); ref_tick = 1'b0;
    chk("R9 ends at next ref edge", cp_hiz, 1'b0);
    chk("R9 brst at exit", b_cnt_rst, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule